// File: doc/BRIEF.md
# Context-Tagged Translation Buffer

A small fully associative cache of address translations for a single core. Each slot maps a virtual page number to a physical page number. The slot also holds a process context tag, a flag that marks the mapping as shared by every context, a write-permission bit, and copies of the page-table accessed and dirty bits. Because of the tags, translations from several processes can stay resident at once, and a context switch does not have to discard them.

A lookup is combinational. It takes a virtual address, the current context and a read/write flag, and it returns hit, physical address, permission fault, a dirty-update request and the stored accessed bit, all in the same cycle. A page walker installs entries through the fill port. The maintenance port drops every mapping of one page, or flushes the whole buffer. Fill and maintenance commands take effect at the next rising clock edge. The buffer never changes the accessed or dirty bits by itself. When a write reaches a clean page, the block reports a miss and asks the walker to update memory and refill the entry.

Top module: `ctx_tlb`

## Requirements
- R1: A lookup hits only when a valid entry holds the lookup's virtual page number (address bits 31:12) and the entry's context tag equals the current 4-bit context.
- R2: An entry filled with the shared flag set matches the lookup's page from every current context value.
- R3: On a hit, the physical address is the entry's physical page number in bits 31:12 and the lookup's bits 11:0 unchanged.
- R4: A write lookup that matches an entry whose write-permission bit is 0 returns hit=1 and fault=1. A read lookup never faults.
- R5: A write lookup that matches a writable entry whose dirty bit is 0 returns hit=0 and dirty-update request=1. A read lookup hits whatever the dirty bit holds. The accessed output equals the matching entry's stored accessed bit and is 0 when nothing matches.
- R6: A fill whose page and context are not already present writes the slot named by a round-robin pointer. The pointer starts at slot 0 after reset and advances by one per such fill, wrapping after the last slot.
- R7: A fill whose page, shared flag and context (the context is ignored when the flag is set) match a valid entry overwrites that entry in place and leaves the pointer unchanged.
- R8: A page invalidate removes every entry whose virtual page number equals that of the given address, whatever its context or shared flag.
- R9: A full flush clears every valid entry at the next edge and leaves the replacement pointer unchanged.
- R10: When an invalidate or flush is given in the same cycle as a fill, the fill is dropped and the pointer does not move.
- R11: A synchronous reset clears all valid bits, so every lookup misses afterwards.
- R12: When several valid entries match one lookup, the entry in the lowest-numbered slot supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_ctx | input | 4 | Current context |
| lk_write | input | 1 | 1 = write access, 0 = read |
| lk_hit | output | 1 | Translation usable |
| lk_paddr | output | 32 | Translated physical address |
| lk_fault | output | 1 | Write to a page without write permission |
| lk_dirty_req | output | 1 | Write to a clean page; walker must set the dirty bit and refill |
| lk_accessed | output | 1 | Stored accessed bit of the matching entry |
| fill_en | input | 1 | Install an entry |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_ctx | input | 4 | Context tag to install |
| fill_global | input | 1 | Entry is shared by all contexts |
| fill_ppn | input | 20 | Physical page number to install |
| fill_writable | input | 1 | Write permission |
| fill_accessed | input | 1 | Accessed bit copy |
| fill_dirty | input | 1 | Dirty bit copy |
| inv_page | input | 1 | Invalidate every entry of one page |
| inv_all | input | 1 | Flush all entries |
| inv_vaddr | input | 32 | Address whose page is invalidated |

## Verification
The bench builds the buffer with ENTRIES=4 and keeps the address and context widths at their defaults. With only four slots, a fifth fill already wraps the round-robin pointer and evicts a live entry. Shared and private entries for the same page then sit next to each other, so the lowest-slot priority can be observed. After every command the bench runs a full sweep over five pages, all four low contexts and both access types, and checks it against a slot-level model kept in the bench.

// File: rtl/ctx_tlb.sv
module ctx_tlb #(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int PG_W    = 12,
  parameter int CTX_W   = 4,
  localparam int VPN_W  = VA_W - PG_W,
  localparam int PPN_W  = PA_W - PG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic [CTX_W-1:0] lk_ctx,
  input  logic             lk_write,
  output logic             lk_hit,
  output logic [PA_W-1:0]  lk_paddr,
  output logic             lk_fault,
  output logic             lk_dirty_req,
  output logic             lk_accessed,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [CTX_W-1:0] fill_ctx,
  input  logic             fill_global,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_writable,
  input  logic             fill_accessed,
  input  logic             fill_dirty,
  input  logic             inv_page,
  input  logic             inv_all,
  input  logic [VA_W-1:0]  inv_vaddr
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] val, glb, wok, acc, drt;
  logic [VPN_W-1:0]   vpn [ENTRIES];
  logic [CTX_W-1:0]   ctx [ENTRIES];
  logic [PPN_W-1:0]   ppn [ENTRIES];
  logic [IDX_W-1:0]   ptr, ptr_nxt;

  wire [VPN_W-1:0] lk_vpn  = lk_vaddr[VA_W-1:PG_W];
  wire [VPN_W-1:0] inv_vpn = inv_vaddr[VA_W-1:PG_W];

  logic [ENTRIES-1:0] lk_m, fl_m;
  logic               lk_any, fl_any;
  logic [IDX_W-1:0]   lk_sel, fl_sel, wr_idx;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      lk_m[i] = val[i] && vpn[i] == lk_vpn && (glb[i] || ctx[i] == lk_ctx);
      fl_m[i] = val[i] && vpn[i] == fill_vpn && glb[i] == fill_global
                && (fill_global || ctx[i] == fill_ctx);
    end
    lk_any = 1'b0; lk_sel = '0;
    fl_any = 1'b0; fl_sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_m[i]) begin lk_any = 1'b1; lk_sel = IDX_W'(i); end
      if (fl_m[i]) begin fl_any = 1'b1; fl_sel = IDX_W'(i); end
    end
  end

  assign lk_fault     = lk_any & lk_write & ~wok[lk_sel];
  assign lk_dirty_req = lk_any & lk_write & wok[lk_sel] & ~drt[lk_sel];
  assign lk_hit       = lk_any & ~lk_dirty_req;
  assign lk_accessed  = lk_any & acc[lk_sel];
  assign lk_paddr     = {ppn[lk_sel], lk_vaddr[PG_W-1:0]};

  assign ptr_nxt = (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
  assign wr_idx  = fl_any ? fl_sel : ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      val <= '0;
      ptr <= '0;
    end else if (inv_all) begin
      val <= '0;
    end else if (inv_page) begin
      for (int i = 0; i < ENTRIES; i++)
        if (vpn[i] == inv_vpn) val[i] <= 1'b0;
    end else if (fill_en) begin
      val[wr_idx] <= 1'b1;
      glb[wr_idx] <= fill_global;
      wok[wr_idx] <= fill_writable;
      acc[wr_idx] <= fill_accessed;
      drt[wr_idx] <= fill_dirty;
      vpn[wr_idx] <= fill_vpn;
      ctx[wr_idx] <= fill_ctx;
      ppn[wr_idx] <= fill_ppn;
      if (!fl_any) ptr <= ptr_nxt;
    end
  end

  // R5
  dirty_req_excl_chk: assert property (@(posedge clk) disable iff (rst)
    lk_dirty_req |-> (!lk_hit && lk_write));
  // R4
  fault_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    lk_fault |-> (lk_write && lk_hit));
  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
    inv_all |=> (val == '0));
  // R11
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (val == '0 && ptr == '0));
  // R10
  inv_blocks_fill_chk: assert property (@(posedge clk) disable iff (rst)
    ((inv_page || inv_all) && fill_en) |=> $stable(ptr));

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_inv
      // R8
      page_dropped_chk: assert property (@(posedge clk) disable iff (rst)
        inv_page |=> !(val[g] && vpn[g] == $past(inv_vpn)));
    end
  endgenerate
endmodule

// File: tb/test_ctx_tlb.sv
module test_ctx_tlb;
  localparam int E = 4;
  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic [31:0] lk_vaddr = '0, inv_vaddr = '0, lk_paddr;
  logic [3:0]  lk_ctx = '0, fill_ctx = '0;
  logic        lk_write = 1'b0, lk_hit, lk_fault, lk_dirty_req, lk_accessed;
  logic        fill_en = 0, fill_global = 0, fill_writable = 0, fill_accessed = 0, fill_dirty = 0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;
  logic        inv_page = 0, inv_all = 0;

  ctx_tlb #(.ENTRIES(E)) i_ctx_tlb (.*);

  int checks = 0, fails = 0;
  logic        m_v [E], m_g [E], m_w [E], m_a [E], m_d [E];
  logic [19:0] m_vpn [E], m_ppn [E];
  logic [3:0]  m_ctx [E];
  int          m_ptr = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < E; i++) m_v[i] = 0;
    m_ptr = 0;
  endtask

  task automatic cmd(input logic fe, input logic [19:0] vpn, input logic [3:0] cx,
                     input logic gl, input logic [19:0] pp, input logic w, a, d,
                     input logic ip, ia, input logic [19:0] ivpn);
    int k;
    @(negedge clk);
    fill_en = fe; fill_vpn = vpn; fill_ctx = cx; fill_global = gl; fill_ppn = pp;
    fill_writable = w; fill_accessed = a; fill_dirty = d;
    inv_page = ip; inv_all = ia; inv_vaddr = {ivpn, 12'h3c7};
    if (ia) begin
      for (int i = 0; i < E; i++) m_v[i] = 0;
    end else if (ip) begin
      for (int i = 0; i < E; i++) if (m_vpn[i] == ivpn) m_v[i] = 0;   // R8
    end else if (fe) begin
      k = -1;
      for (int i = E - 1; i >= 0; i--)
        if (m_v[i] && m_vpn[i] == vpn && m_g[i] == gl && (gl || m_ctx[i] == cx)) k = i; // R7
      if (k < 0) begin k = m_ptr; m_ptr = (m_ptr + 1) % E; end      // R6
      m_v[k] = 1; m_vpn[k] = vpn; m_ctx[k] = cx; m_g[k] = gl; m_ppn[k] = pp;
      m_w[k] = w; m_a[k] = a; m_d[k] = d;
    end
    @(negedge clk);
    fill_en = 0; inv_page = 0; inv_all = 0;
  endtask

  task automatic sweep();
    int s;
    logic any, fault, dreq, hit;
    for (int vp = 0; vp < 5; vp++)
      for (int cx = 0; cx < 4; cx++)
        for (int w = 0; w < 2; w++) begin
          lk_vaddr = {20'(vp), 12'(vp * 331 + cx * 17 + w)};
          lk_ctx = 4'(cx); lk_write = w[0];
          #1;
          s = -1;
          for (int i = E - 1; i >= 0; i--)                      // R12 lowest slot wins
            if (m_v[i] && m_vpn[i] == 20'(vp) && (m_g[i] || m_ctx[i] == 4'(cx))) s = i; // R1 R2
          any = (s >= 0);
          fault = any && w == 1 && !m_w[s];
          dreq  = any && w == 1 && m_w[s] && !m_d[s];
          hit   = any && !dreq;
          chk("R1 hit", 32'(lk_hit), 32'(hit));
          chk("R4 fault", 32'(lk_fault), 32'(fault));
          chk("R5 dirty_req", 32'(lk_dirty_req), 32'(dreq));
          chk("R5 accessed", 32'(lk_accessed), 32'(any && m_a[s]));
          if (hit) chk("R3 paddr", lk_paddr, {m_ppn[s], lk_vaddr[11:0]});
        end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    sweep();                                                          // R11
    cmd(1, 20'd1, 4'd0, 0, 20'hA0001, 1, 1, 1, 0, 0, 0); sweep();     // R1
    cmd(1, 20'd2, 4'd1, 0, 20'hA0002, 0, 0, 0, 0, 0, 0); sweep();     // R4
    cmd(1, 20'd3, 4'd9, 1, 20'hA0003, 1, 1, 0, 0, 0, 0); sweep();     // R2 R5
    cmd(1, 20'd1, 4'd2, 0, 20'hA0004, 1, 0, 0, 0, 0, 0); sweep();
    cmd(1, 20'd4, 4'd3, 0, 20'hA0005, 1, 1, 1, 0, 0, 0); sweep();     // R6 wrap
    cmd(1, 20'd3, 4'd5, 1, 20'hB0003, 1, 1, 1, 0, 0, 0); sweep();     // R7 in place
    cmd(1, 20'd1, 4'd7, 1, 20'hC0001, 0, 1, 1, 0, 0, 0); sweep();     // R12
    cmd(1, 20'd0, 4'd0, 0, 20'hD0000, 1, 1, 1, 1, 0, 20'd1); sweep(); // R8 R10
    cmd(1, 20'd0, 4'd0, 0, 20'hD0000, 1, 1, 1, 0, 0, 0); sweep();     // R6
    cmd(1, 20'd2, 4'd2, 0, 20'hE0002, 1, 0, 1, 0, 1, 0); sweep();     // R9 R10
    cmd(1, 20'd2, 4'd2, 0, 20'hE0002, 1, 0, 1, 0, 0, 0); sweep();
    cmd(1, 20'd4, 4'd1, 1, 20'hE0004, 0, 1, 0, 0, 0, 0); sweep();
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    model_reset();
    sweep();                                                          // R11
    cmd(1, 20'd3, 4'd0, 0, 20'hF0003, 1, 1, 1, 0, 0, 0); sweep();     // R6 pointer from slot 0
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule